// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block gathers interrupt requests from the eight IN endpoints and the eight OUT endpoints of a USB device controller. It merges them into a single sticky interrupt line for the embedded processor. Each endpoint's logic sends a one-cycle request pulse. The block stores that pulse in a pending bit whether or not the endpoint is enabled. The pending bit feeds the combined interrupt only while the matching enable bit is set. Because of this, a request that arrived while masked raises the interrupt as soon as software enables it.

Software reaches the block through a small memory-mapped register bus. Four byte-wide registers sit at consecutive offsets from a parameterised base address: two enable registers, then two pending registers. The pending bits are cleared by writing 1 to them. The interrupt flag sets only while the processor's local enable for this interrupt source and its global interrupt enable are both high. Once set, it stays high until the processor acknowledges it.

Top module: `usb_ep_irq_agg`

## Requirements
- R1: Reset sets the IN enable bits to 0, the OUT enable bits to the parameter `OUT_EN_RESET`, every pending bit to 0, and `irq_out` to 0.
- R2: The IN enable register is at offset 0 and the OUT enable register at offset 1. Bit n controls endpoint n. A write takes effect at the clock edge. A read returns the stored value combinationally, in the same cycle as the address.
- R3: A pulse on bit n of `ep_in_req` or `ep_out_req` sets the matching pending bit at that clock edge, whatever the state of the enable bit.
- R4: IN pending is read at offset 2 and OUT pending at offset 3. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R5: When a new request and a write-1 clear hit the same pending bit in the same cycle, the bit stays set.
- R6: When any pending bit has its enable set, and `loc_irq_en` and `glb_irq_en` are both 1, `irq_out` goes to 1 at the next clock edge.
- R7: A pending bit whose enable is 0 does not raise `irq_out`, and it stays pending. Setting its enable later raises `irq_out` one edge after the enable write.
- R8: While either `loc_irq_en` or `glb_irq_en` is 0, `irq_out` does not set.
- R9: `irq_out` stays at 1 after the pending bits are cleared. A pulse on `irq_ack` clears it, unless the set condition of R6 holds in that same cycle, in which case it stays at 1.
- R10: Writes to addresses outside the four registers change nothing. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | EP_N | Register write data |
| bus_rdata | output | EP_N | Combinational read data for `bus_addr` |
| ep_in_req | input | EP_N | Request pulses from the IN endpoints, bit n is endpoint n |
| ep_out_req | input | EP_N | Request pulses from the OUT endpoints, bit n is endpoint n |
| loc_irq_en | input | 1 | Processor's local enable for this interrupt source |
| glb_irq_en | input | 1 | Processor's global interrupt enable |
| irq_ack | input | 1 | Processor clear of the sticky interrupt |
| irq_out | output | 1 | Sticky combined interrupt request |

## Verification
Each result arrives at a fixed number of clock edges after its stimulus:

- **Read data:** combinational, with no edge between the address and the value.
- **Enable and pending registers:** change at the edge that samples a write or a request pulse.
- **`irq_out`:** changes one edge after the register change that makes the set condition true, or at the edge that samples `irq_ack`.

The bench drives every input and samples every output 1 ns after a rising edge, so each stimulus is seen at exactly one edge. Each check is placed at the edge count given above. It also checks that `irq_out` is still 0 in the cycle just before it is due to rise, so a design that is one edge early is caught as well as one that is late.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;

    // Register selected by a bus access; SEL_NONE covers every unmapped address.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN_EN,
        SEL_OUT_EN,
        SEL_IN_PEND,
        SEL_OUT_PEND
    } reg_sel_e;

    localparam int unsigned REG_COUNT = 4;
    localparam int unsigned DIR_IN    = 0;
    localparam int unsigned DIR_OUT   = 1;

    // Map an in-range register offset to its register.
    function automatic reg_sel_e decode_sel(input logic in_range, input logic [1:0] off);
        reg_sel_e s;
        s = SEL_NONE;
        if (in_range) begin
            case (off)
                2'd0:    s = SEL_IN_EN;
                2'd1:    s = SEL_OUT_EN;
                2'd2:    s = SEL_IN_PEND;
                default: s = SEL_OUT_PEND;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/usb_ep_pending.sv
module usb_ep_pending #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_q;

    // A new request overrides a clear of the same bit.
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_mask) | req;
    end

    assign pend = pend_q;

    AST_REQ_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |=> ((pend_q & $past(req)) == $past(req)));                 // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~req) != '0) |=> ((pend_q & $past(clr_mask & ~req)) == '0)); // R4
    AST_REQ_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & req) != '0) |=> ((pend_q & $past(clr_mask & req)) == $past(clr_mask & req))); // R5
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (req == '0 && clr_mask == '0) |=> $stable(pend_q));                     // R4

endmodule

// File: rtl/usb_ep_enable_regs.sv
module usb_ep_enable_regs
    import usb_ep_irq_pkg::*;
#(
    parameter int unsigned N            = 8,
    parameter logic [N-1:0] OUT_EN_RESET = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] in_en,
    output logic [N-1:0] out_en
);
    logic [N-1:0] in_en_q, out_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_en_q  <= '0;
            out_en_q <= OUT_EN_RESET;
        end else if (wr) begin
            if (sel == SEL_IN_EN)  in_en_q  <= wdata;
            if (sel == SEL_OUT_EN) out_en_q <= wdata;
        end
    end

    assign in_en  = in_en_q;
    assign out_en = out_en_q;

    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wr && (sel == SEL_IN_EN || sel == SEL_OUT_EN)) |=> ($stable(in_en_q) && $stable(out_en_q))); // R2

endmodule

// File: rtl/usb_ep_irq_latch.sv
module usb_ep_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic loc_en,
    input  logic glb_en,
    input  logic ack,
    output logic flag
);
    logic flag_q;
    logic set_c;

    assign set_c = hit && loc_en && glb_en;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_c) flag_q <= 1'b1;
        else if (ack)   flag_q <= 1'b0;
    end

    assign flag = flag_q;

    AST_SETS_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (hit && loc_en && glb_en) |=> flag_q);                                  // R6
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(hit && loc_en && glb_en));                      // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ack) |=> flag_q);                                           // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !(hit && loc_en && glb_en)) |=> !flag_q);                       // R9

endmodule

// File: rtl/usb_ep_irq_agg.sv
module usb_ep_irq_agg
    import usb_ep_irq_pkg::*;
#(
    parameter int unsigned      EP_N         = 8,
    parameter int unsigned      ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'h0040,
    parameter logic [EP_N-1:0]  OUT_EN_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [EP_N-1:0]   bus_wdata,
    output logic [EP_N-1:0]   bus_rdata,
    input  logic [EP_N-1:0]   ep_in_req,
    input  logic [EP_N-1:0]   ep_out_req,
    input  logic              loc_irq_en,
    input  logic              glb_irq_en,
    input  logic              irq_ack,
    output logic              irq_out
);
    localparam int unsigned DIRS = 2;

    logic [ADDR_W-1:0]         off;
    logic                      in_range;
    reg_sel_e                  sel;
    logic [EP_N-1:0]           in_en, out_en;
    logic [DIRS-1:0][EP_N-1:0] req_v, clr_v, pend_v, en_v;
    logic                      hit;

    assign off      = bus_addr - BASE_ADDR;
    assign in_range = (bus_addr >= BASE_ADDR) && (off < ADDR_W'(REG_COUNT));
    assign sel      = decode_sel(in_range, off[1:0]);

    usb_ep_enable_regs #(.N(EP_N), .OUT_EN_RESET(OUT_EN_RESET)) u_en (
        .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
        .in_en(in_en), .out_en(out_en)
    );

    assign req_v[DIR_IN]  = ep_in_req;
    assign req_v[DIR_OUT] = ep_out_req;
    assign clr_v[DIR_IN]  = (bus_wr && sel == SEL_IN_PEND)  ? bus_wdata : '0;
    assign clr_v[DIR_OUT] = (bus_wr && sel == SEL_OUT_PEND) ? bus_wdata : '0;
    assign en_v[DIR_IN]   = in_en;
    assign en_v[DIR_OUT]  = out_en;

    for (genvar d = 0; d < DIRS; d++) begin : g_dir
        usb_ep_pending #(.N(EP_N)) u_pend (
            .clk(clk), .rst(rst), .req(req_v[d]), .clr_mask(clr_v[d]), .pend(pend_v[d])
        );
    end

    // Enabled requests from both directions OR-reduced into one line.
    assign hit = |(pend_v & en_v);

    usb_ep_irq_latch u_latch (
        .clk(clk), .rst(rst), .hit(hit), .loc_en(loc_irq_en), .glb_en(glb_irq_en),
        .ack(irq_ack), .flag(irq_out)
    );

    always_comb begin
        case (sel)
            SEL_IN_EN:    bus_rdata = in_en;
            SEL_OUT_EN:   bus_rdata = out_en;
            SEL_IN_PEND:  bus_rdata = pend_v[DIR_IN];
            SEL_OUT_PEND: bus_rdata = pend_v[DIR_OUT];
            default:      bus_rdata = '0;
        endcase
    end

    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !in_range) |=> ($stable(in_en) && $stable(out_en)));        // R10
    AST_MASKED_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!irq_out && (pend_v & en_v) == '0) |=> !irq_out);                     // R7

endmodule

// File: tb/usb_ep_irq_agg_test.sv
`timescale 1ns/100ps
module usb_ep_irq_agg_test;
    localparam int unsigned      EP_N    = 8;
    localparam int unsigned      ADDR_W  = 16;
    localparam logic [ADDR_W-1:0] BASE    = 16'h0040;
    localparam logic [EP_N-1:0]  OUT_RST = 8'h5A;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [EP_N-1:0]   bus_wdata = '0;
    logic [EP_N-1:0]   bus_rdata;
    logic [EP_N-1:0]   ep_in_req = '0, ep_out_req = '0;
    logic              loc_irq_en = 1'b0, glb_irq_en = 1'b0, irq_ack = 1'b0;
    logic              irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    usb_ep_irq_agg #(.EP_N(EP_N), .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .OUT_EN_RESET(OUT_RST)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ep_in_req(ep_in_req), .ep_out_req(ep_out_req),
        .loc_irq_en(loc_irq_en), .glb_irq_en(glb_irq_en), .irq_ack(irq_ack), .irq_out(irq_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [EP_N-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [EP_N-1:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic pulse_in(input logic [EP_N-1:0] m);
        ep_in_req = m; tick(); ep_in_req = '0;
    endtask

    task automatic pulse_out(input logic [EP_N-1:0] m);
        ep_out_req = m; tick(); ep_out_req = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 in_en", BASE + 16'd0, 8'h00);
        rd_chk("R1 out_en", BASE + 16'd1, OUT_RST);
        rd_chk("R1 in_pend", BASE + 16'd2, 8'h00);
        rd_chk("R1 out_pend", BASE + 16'd3, 8'h00);
        chk("R1 irq", 32'(irq_out), 32'd0);
    endtask

    task automatic t_enable_rw();
        wr(BASE + 16'd0, 8'hA5);
        rd_chk("R2 in_en rw", BASE + 16'd0, 8'hA5);
        wr(BASE + 16'd1, 8'h3C);
        rd_chk("R2 out_en rw", BASE + 16'd1, 8'h3C);
        rd_chk("R2 in_en kept", BASE + 16'd0, 8'hA5);
        wr(BASE + 16'd0, 8'h00);
        wr(BASE + 16'd1, 8'h00);
    endtask

    task automatic t_masked_then_enabled();
        loc_irq_en = 1'b1; glb_irq_en = 1'b1;
        pulse_in(8'h81);
        rd_chk("R3 capture while masked", BASE + 16'd2, 8'h81);
        tick(); tick();
        chk("R7 masked no irq", 32'(irq_out), 32'd0);
        wr(BASE + 16'd0, 8'h01);
        chk("R7 not yet at enable edge", 32'(irq_out), 32'd0);
        tick();
        chk("R7 irq after enable", 32'(irq_out), 32'd1);
    endtask

    task automatic t_w1c_sticky();
        wr(BASE + 16'd2, 8'h00);
        rd_chk("R4 write 0 no effect", BASE + 16'd2, 8'h81);
        ack();
        chk("R9 ack ignored while set cond", 32'(irq_out), 32'd1);
        wr(BASE + 16'd2, 8'h80);
        rd_chk("R4 w1c single bit", BASE + 16'd2, 8'h01);
        wr(BASE + 16'd2, 8'h01);
        rd_chk("R4 w1c all", BASE + 16'd2, 8'h00);
        tick();
        chk("R9 sticky after clear", 32'(irq_out), 32'd1);
        ack();
        chk("R9 ack clears", 32'(irq_out), 32'd0);
    endtask

    task automatic t_collision();
        pulse_out(8'h11);
        rd_chk("R3 out capture", BASE + 16'd3, 8'h11);
        bus_addr = BASE + 16'd3; bus_wdata = 8'h11; bus_wr = 1'b1; ep_out_req = 8'h10;
        tick();
        bus_wr = 1'b0; ep_out_req = '0;
        rd_chk("R5 request beats clear", BASE + 16'd3, 8'h10);
        wr(BASE + 16'd3, 8'h10);
        rd_chk("R4 out cleared", BASE + 16'd3, 8'h00);
        chk("R7 out masked no irq", 32'(irq_out), 32'd0);
    endtask

    task automatic t_gates();
        wr(BASE + 16'd1, 8'h02);
        loc_irq_en = 1'b0; glb_irq_en = 1'b1;
        pulse_out(8'h02);
        tick(); tick();
        chk("R8 local enable low", 32'(irq_out), 32'd0);
        loc_irq_en = 1'b1; glb_irq_en = 1'b0;
        tick(); tick();
        chk("R8 global enable low", 32'(irq_out), 32'd0);
        glb_irq_en = 1'b1;
        chk("R6 not before edge", 32'(irq_out), 32'd0);
        tick();
        chk("R6 irq one edge later", 32'(irq_out), 32'd1);
        wr(BASE + 16'd3, 8'h02);
        ack();
        chk("R9 cleared", 32'(irq_out), 32'd0);
        pulse_out(8'h02);
        chk("R6 timing from request", 32'(irq_out), 32'd0);
        tick();
        chk("R6 set from request", 32'(irq_out), 32'd1);
        wr(BASE + 16'd3, 8'h02);
        ack();
    endtask

    task automatic t_unmapped();
        wr(BASE + 16'd4, 8'hFF);
        wr(BASE - 16'd1, 8'hFF);
        wr(BASE + 16'h0100, 8'hFF);
        rd_chk("R10 in_en unchanged", BASE + 16'd0, 8'h01);
        rd_chk("R10 out_en unchanged", BASE + 16'd1, 8'h02);
        rd_chk("R10 read unmapped zero", BASE + 16'd5, 8'h00);
        rd_chk("R10 read below base zero", BASE - 16'd1, 8'h00);
        chk("R10 irq untouched", 32'(irq_out), 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        t_reset();
        t_enable_rw();
        t_masked_then_enabled();
        t_w1c_sticky();
        t_collision();
        t_gates();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule